// File: doc/BRIEF.md
# Burst-Ready Decision Logic for a Cache Tag Block

This block makes the cache hit and ready decision inside the tag block itself. It drives an active-low burst-ready strobe to the processor. It works from three kinds of input:

- the comparator result and the status bits of the addressed line;
- the processor's write/read indication;
- a clocked external ready input.

Tag storage is outside the block. The comparator result and the stored valid and write-through bits arrive as plain inputs.

On a valid hit the strobe is pulled low. A write to a line marked write-through keeps the strobe high, so the write still goes out to memory. A read of the same line still reports the hit. Several other conditions hold the strobe high:

- a force-high control;
- a status clear that is in progress;
- a tag write that is in progress.

An external ready source is sampled on each rising clock edge. A low sample is merged with the hit term, so the strobe goes low after that edge.

The output comes as a level plus a drive enable. When the enable is off, the level is parked high.

The block has two status modes, selected by an input:

- **Dedicated mode:** the valid bit qualifies the hit, and the write-through bit can suppress writes.
- **Generic mode:** the status bits carry no fixed meaning. The comparator result alone counts as a hit, and no write-through suppression applies.

Top module: `brdy_gen_top`

## Requirements
- R1: The drive enable `rdy_oe` is 1 exactly when `oe_n` is 0 and `cs_sel` is 1. Whenever it is 0, `rdy_n` is 1.
- R2: While enabled, a 0 on the synchronous clear input `clr_n` holds `rdy_n` at 1.
- R3: While enabled and not clearing, `force_hi` = 1 holds `rdy_n` at 1. This overrides both the hit and the external ready.
- R4: In dedicated mode (`mode_gen` = 0), a stored write-through bit of 1 together with `wr_cyc` = 1 holds `rdy_n` at 1. With `wr_cyc` = 0 on the same line, the hit is still reported.
- R5: In dedicated mode, `match_i` = 1 with `vld_i` = 1 drives `rdy_n` to 0 when no rule above applies. With `vld_i` = 0, the match is ignored.
- R6: In generic mode (`mode_gen` = 1), `match_i` = 1 alone drives `rdy_n` to 0 when no rule above applies. Neither `vld_i` nor `wt_i` has any effect.
- R7: While `tag_wr` = 1, `rdy_n` is 1. This rule ranks below force-high and above write-through suppression.
- R8: `ext_rdy_n` is sampled at each rising edge. A 0 sample drives `rdy_n` to 0 from that edge until the next edge, when no rule above applies.
- R9: A rising edge that sees `cs_sel` = 0 or `clr_n` = 0 stores an inactive external-ready sample, whatever `ext_rdy_n` is.
- R10: If there is no qualified hit and the stored external sample is inactive, `rdy_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; external ready is sampled on the rising edge |
| clr_n | input | 1 | Synchronous status clear, active low; also clears the ready sample |
| cs_sel | input | 1 | Combined chip-select result, 1 = selected |
| match_i | input | 1 | Tag comparator result, 1 = equal |
| vld_i | input | 1 | Stored valid bit of the addressed line |
| wt_i | input | 1 | Stored write-through bit of the addressed line |
| mode_gen | input | 1 | 0 = dedicated status meaning, 1 = generic status bits |
| wr_cyc | input | 1 | Processor cycle type, 1 = write, 0 = read |
| tag_wr | input | 1 | Tag write in progress |
| ext_rdy_n | input | 1 | External ready, active low, sampled at the clock |
| force_hi | input | 1 | Forces the ready strobe inactive |
| oe_n | input | 1 | Ready output enable, active low |
| rdy_n | output | 1 | Burst-ready strobe, active low |
| rdy_oe | output | 1 | Drive enable for `rdy_n`, 1 = drive |

## Verification
The clocked properties assume that the match, status, mode and control inputs are steady around the rising edge. This matches a combinational output that the processor samples on that edge. The bench meets this by changing every input only at the falling edge and reading the outputs 1 ns later.

The external-ready properties look back exactly one edge. They take for granted that the sample is meaningful only after the first edge that follows a clear. The bench holds `clr_n` low over several edges before it does any sweep, and it primes each stored sample with `cs_sel` and `clr_n` both high.

// File: rtl/brdy_pkg.sv
package brdy_pkg;

   // Source that decides the strobe level, highest priority first.
   typedef enum logic [2:0] {
      SRC_OFF   = 3'd0,
      SRC_CLR   = 3'd1,
      SRC_FORCE = 3'd2,
      SRC_TAGWR = 3'd3,
      SRC_WTWR  = 3'd4,
      SRC_EXT   = 3'd5,
      SRC_HIT   = 3'd6,
      SRC_IDLE  = 3'd7
   } brdy_src_e;

   // Only the external sample and the qualified hit assert the strobe.
   function automatic logic src_asserts(input brdy_src_e s);
      return (s == SRC_EXT) || (s == SRC_HIT);
   endfunction

endpackage

// File: rtl/brdy_ext_sampler.sv
module brdy_ext_sampler #(
   parameter int HAS_EXT_RDY = 1
) (
   input  logic clk,
   input  logic clr_n,
   input  logic cs_sel,
   input  logic ext_rdy_n,
   output logic ext_seen
);

   if (HAS_EXT_RDY != 0 && HAS_EXT_RDY != 1) begin : g_bad_cfg
      $error("brdy_ext_sampler: HAS_EXT_RDY must be 0 or 1");
   end

   if (HAS_EXT_RDY == 1) begin : g_ext
      logic seen_q;

      always_ff @(posedge clk) begin
         if (!clr_n || !cs_sel) begin
            seen_q <= 1'b0;
         end else begin
            seen_q <= ~ext_rdy_n;
         end
      end

      assign ext_seen = seen_q;

      // R9: deselect or clear at an edge leaves no pending external ready
      a_r9_desel_clears : assert property (@(posedge clk)
         (!cs_sel || !clr_n) |=> !ext_seen)
         else $error("a_r9_desel_clears");
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ^{clk, clr_n, cs_sel, ext_rdy_n};
      assign ext_seen   = 1'b0;
   end

endmodule

// File: rtl/brdy_hit_qual.sv
module brdy_hit_qual #(
   parameter int WT_SUPPRESS = 1
) (
   input  logic clk,
   input  logic clr_n,
   input  logic match_i,
   input  logic vld_i,
   input  logic wt_i,
   input  logic mode_gen,
   input  logic wr_cyc,
   output logic hit,
   output logic wt_block
);

   if (WT_SUPPRESS != 0 && WT_SUPPRESS != 1) begin : g_bad_cfg
      $error("brdy_hit_qual: WT_SUPPRESS must be 0 or 1");
   end

   logic valid_ok;

   // Generic mode drops the valid qualifier.
   assign valid_ok = mode_gen | vld_i;
   assign hit      = match_i & valid_ok;

   if (WT_SUPPRESS == 1) begin : g_wt
      assign wt_block = ~mode_gen & wt_i & wr_cyc;
   end else begin : g_no_wt
      logic unused_wt;
      assign unused_wt = ^{wt_i, wr_cyc};
      assign wt_block  = 1'b0;
   end

   // R10 / R5: an invalid line never yields a hit in dedicated mode
   a_r10_invalid_no_hit : assert property (@(posedge clk) disable iff (!clr_n)
      (!mode_gen && !vld_i) |-> !hit)
      else $error("a_r10_invalid_no_hit");

   // R6: generic mode never suppresses
   a_r6_generic_no_block : assert property (@(posedge clk) disable iff (!clr_n)
      mode_gen |-> !wt_block)
      else $error("a_r6_generic_no_block");

endmodule

// File: rtl/brdy_arbiter.sv
module brdy_arbiter
   import brdy_pkg::*;
(
   input  logic clk,
   input  logic out_en,
   input  logic clr_n,
   input  logic force_hi,
   input  logic tag_wr,
   input  logic wt_block,
   input  logic ext_seen,
   input  logic hit,
   output logic rdy_n
);

   brdy_src_e src;

   always_comb begin
      if (!out_en)        src = SRC_OFF;
      else if (!clr_n)    src = SRC_CLR;
      else if (force_hi)  src = SRC_FORCE;
      else if (tag_wr)    src = SRC_TAGWR;
      else if (wt_block)  src = SRC_WTWR;
      else if (ext_seen)  src = SRC_EXT;
      else if (hit)       src = SRC_HIT;
      else                src = SRC_IDLE;
   end

   assign rdy_n = ~src_asserts(src);

   // R3: force-high wins over any assertion source
   a_r3_force_wins : assert property (@(posedge clk) disable iff (!clr_n)
      (force_hi && (ext_seen || hit)) |-> rdy_n)
      else $error("a_r3_force_wins");

   // R7: tag write suppresses
   a_r7_tagwr_quiet : assert property (@(posedge clk) disable iff (!clr_n)
      tag_wr |-> rdy_n)
      else $error("a_r7_tagwr_quiet");

endmodule

// File: rtl/brdy_gen_top.sv
module brdy_gen_top #(
   parameter int HAS_EXT_RDY = 1,
   parameter int WT_SUPPRESS = 1
) (
   input  logic clk,
   input  logic clr_n,
   input  logic cs_sel,
   input  logic match_i,
   input  logic vld_i,
   input  logic wt_i,
   input  logic mode_gen,
   input  logic wr_cyc,
   input  logic tag_wr,
   input  logic ext_rdy_n,
   input  logic force_hi,
   input  logic oe_n,
   output logic rdy_n,
   output logic rdy_oe
);

   logic out_en;
   logic ext_seen;
   logic hit;
   logic wt_block;

   assign out_en = ~oe_n & cs_sel;
   assign rdy_oe = out_en;

   brdy_ext_sampler #(.HAS_EXT_RDY(HAS_EXT_RDY)) u_ext (
      .clk       (clk),
      .clr_n     (clr_n),
      .cs_sel    (cs_sel),
      .ext_rdy_n (ext_rdy_n),
      .ext_seen  (ext_seen)
   );

   brdy_hit_qual #(.WT_SUPPRESS(WT_SUPPRESS)) u_hit (
      .clk      (clk),
      .clr_n    (clr_n),
      .match_i  (match_i),
      .vld_i    (vld_i),
      .wt_i     (wt_i),
      .mode_gen (mode_gen),
      .wr_cyc   (wr_cyc),
      .hit      (hit),
      .wt_block (wt_block)
   );

   brdy_arbiter u_arb (
      .clk      (clk),
      .out_en   (out_en),
      .clr_n    (clr_n),
      .force_hi (force_hi),
      .tag_wr   (tag_wr),
      .wt_block (wt_block),
      .ext_seen (ext_seen),
      .hit      (hit),
      .rdy_n    (rdy_n)
   );

   // R1: a disabled strobe is parked high
   a_r1_off_parked : assert property (@(posedge clk)
      (oe_n || !cs_sel) |-> (!rdy_oe && rdy_n))
      else $error("a_r1_off_parked");

   // R2: clearing holds the strobe inactive
   a_r2_clear_high : assert property (@(posedge clk)
      !clr_n |-> rdy_n)
      else $error("a_r2_clear_high");

   // R4: dedicated write to a write-through line stays inactive
   if (WT_SUPPRESS == 1) begin : g_a_wt
      a_r4_wt_write_high : assert property (@(posedge clk) disable iff (!clr_n)
         (!mode_gen && wt_i && wr_cyc) |-> rdy_n)
         else $error("a_r4_wt_write_high");
   end

   // R5: a valid hit with nothing above it asserts the strobe
   a_r5_valid_hit_low : assert property (@(posedge clk) disable iff (!clr_n)
      (!oe_n && cs_sel && !force_hi && !tag_wr && match_i && vld_i &&
       !(wt_i && wr_cyc)) |-> !rdy_n)
      else $error("a_r5_valid_hit_low");

   // R8: an external low sample asserts the strobe for the following cycle
   if (HAS_EXT_RDY == 1) begin : g_a_ext
      a_r8_ext_low : assert property (@(posedge clk) disable iff (!clr_n)
         ($past(clr_n) && $past(cs_sel) && !$past(ext_rdy_n) &&
          !oe_n && cs_sel && !force_hi && !tag_wr &&
          !(!mode_gen && wt_i && wr_cyc)) |-> !rdy_n)
         else $error("a_r8_ext_low");
   end

endmodule

// File: tb/brdy_gen_top_tb_top.sv
`timescale 1ns/1ps
module brdy_gen_top_tb_top;

   logic clk = 1'b0;
   logic clr_n = 1'b0, cs_sel = 1'b0, match_i = 1'b0, vld_i = 1'b0;
   logic wt_i = 1'b0, mode_gen = 1'b0, wr_cyc = 1'b0, tag_wr = 1'b0;
   logic ext_rdy_n = 1'b1, force_hi = 1'b0, oe_n = 1'b1;
   logic rdy_n, rdy_oe;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   brdy_gen_top dut_i (
      .clk(clk), .clr_n(clr_n), .cs_sel(cs_sel), .match_i(match_i),
      .vld_i(vld_i), .wt_i(wt_i), .mode_gen(mode_gen), .wr_cyc(wr_cyc),
      .tag_wr(tag_wr), .ext_rdy_n(ext_rdy_n), .force_hi(force_hi),
      .oe_n(oe_n), .rdy_n(rdy_n), .rdy_oe(rdy_oe)
   );

   task automatic check(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%b expected=%b (t=%0t)", req, got, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      match_i = 0; vld_i = 0; wt_i = 0; mode_gen = 0; wr_cyc = 0;
      tag_wr = 0; force_hi = 0; oe_n = 0; ext_rdy_n = 1;
   endtask

   initial begin
      // reset state: clear held over several edges
      idle_inputs();
      cs_sel = 1; clr_n = 0;
      repeat (4) @(negedge clk);
      #1;
      check("R2 reset", rdy_n, 1'b1);
      check("R1 reset enable", rdy_oe, 1'b1);

      // exhaustive sweep: 10 input bits x stored external sample
      for (int p = 0; p < 2; p++) begin
         for (int v = 0; v < 1024; v++) begin
            logic e_oe, e_n;
            string tag;
            // prime the external sample
            @(negedge clk);
            idle_inputs();
            cs_sel = 1; clr_n = 1; ext_rdy_n = (p == 0);
            @(negedge clk);
            ext_rdy_n = 1;
            oe_n     = v[0];
            cs_sel   = v[1];
            clr_n    = v[2];
            force_hi = v[3];
            tag_wr   = v[4];
            mode_gen = v[5];
            wt_i     = v[6];
            wr_cyc   = v[7];
            vld_i    = v[8];
            match_i  = v[9];
            #1;
            e_oe = !oe_n && cs_sel;
            if (!e_oe)                          begin e_n = 1; tag = "R1"; end
            else if (!clr_n)                    begin e_n = 1; tag = "R2"; end
            else if (force_hi)                  begin e_n = 1; tag = "R3"; end
            else if (tag_wr)                    begin e_n = 1; tag = "R7"; end
            else if (!mode_gen && wt_i && wr_cyc) begin e_n = 1; tag = "R4"; end
            else if (p == 1)                    begin e_n = 0; tag = "R8"; end
            else if (match_i && mode_gen)       begin e_n = 0; tag = "R6"; end
            else if (match_i && vld_i)          begin e_n = 0; tag = "R5"; end
            else                                begin e_n = 1; tag = "R10"; end
            check({tag, " sweep rdy_n"}, rdy_n, e_n);
            check("R1 sweep rdy_oe", rdy_oe, e_oe);
         end
      end

      // R8: sample lasts one cycle, then a high sample releases it
      @(negedge clk); idle_inputs(); cs_sel = 1; clr_n = 1; ext_rdy_n = 0;
      @(negedge clk); ext_rdy_n = 1; #1;
      check("R8 asserted after edge", rdy_n, 1'b0);
      @(negedge clk); #1;
      check("R8 released after high sample", rdy_n, 1'b1);

      // R9: deselect at the sampling edge discards the low sample
      @(negedge clk); cs_sel = 0; ext_rdy_n = 0;
      @(negedge clk); cs_sel = 1; ext_rdy_n = 1; #1;
      check("R9 deselect clears sample", rdy_n, 1'b1);

      // R9: clear at the sampling edge discards the low sample
      @(negedge clk); clr_n = 0; ext_rdy_n = 0;
      @(negedge clk); clr_n = 1; ext_rdy_n = 1; #1;
      check("R9 clear clears sample", rdy_n, 1'b1);

      // R4: read of a write-through line still reports the hit
      @(negedge clk); match_i = 1; vld_i = 1; wt_i = 1; wr_cyc = 0; #1;
      check("R4 wt read hits", rdy_n, 1'b0);
      wr_cyc = 1; #1;
      check("R4 wt write suppressed", rdy_n, 1'b1);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule